// File: doc/BRIEF.md
# Multiplexed Register Bus Master

This block carries out single-word reads and writes to an external register target over a narrow shared bus. The same pins carry first the address and then the data. Three control lines come with the bus: an active-low chip select, a read/write line and an address/data select line. A host raises a one-cycle start with an address, write data and a write flag. The block runs the whole transaction on its own and pulses done with read data and a fail flag.

Each bus access has four steps. A setup cycle drives the address. The address phase follows with chip select asserted, then the data phase, and chip select is released for one cycle at the end. Both phases last a settle time derived from the clock period and the target's minimum timing. A read is repeated and settles by majority. A write to a state-setting register is confirmed by reading the matching state-reporting register, and the write is retried a bounded number of times if the value does not match. The bus is modelled as separate output, output-enable and input vectors, so the pad cells stay outside the block.

Top module: `mux_reg_bus_master`

## Requirements
- R1: Between transactions and during reset, cs_no is 1, rw_o is 1 (1 = read, 0 = write) and bus_oe_o is all zeros. done_o is 0 except for its completion pulse.
- R2: Every access begins with one cycle in which cs_no is 1, ad_sel_o is 0 (0 = address, 1 = data) and the access address is driven with all enables set. cs_no then falls while that address is held unchanged.
- R3: The address phase and the data phase each last SETTLE_CYC cycles, with SETTLE_CYC = ceil(SETTLE_NS / CLK_NS) and a minimum of 1. cs_no then goes high for one cycle, which ends the access.
- R4: A read access keeps rw_o at 1. During its data phase bus_oe_o is all zeros, and bus_i is sampled in the last data-phase cycle.
- R5: A write access holds rw_o at 0 from the setup cycle to the end of the data phase. During the data phase it drives wdata_i on bus_o with every enable set.
- R6: A read request repeats read accesses. Sample k is accepted as soon as at least floor(VOTES/2) earlier samples equal it. If no sample is accepted by then, the request stops after VOTES samples and returns the last one. rdata_o changes only when a read request completes.
- R7: A write whose address has bit SET_BIT set is followed by a verify read at that address with bit SET_BIT cleared and bit GET_BIT set. A write whose address has bit SET_BIT clear makes exactly one access and no read.
- R8: When a verify read returns a value other than the written data, the write and its verify read are repeated, up to VOTES writes in total. fail_o is 1 only when all of them mismatch, and 0 after any other completion. fail_o changes only together with done_o.
- R9: done_o is a one-cycle pulse per request. fail_o and rdata_o hold their values until the next completion.
- R10: start_i is ignored while a request is in progress. It neither changes the running transaction nor queues a new one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request strobe, taken only when idle |
| we_i | input | 1 | 1 = write request, 0 = read request |
| addr_i | input | DW | Target register address |
| wdata_i | input | DW | Data for a write request |
| done_o | output | 1 | One-cycle completion pulse |
| fail_o | output | 1 | Verified write ran out of attempts |
| rdata_o | output | DW | Result of the last read request |
| cs_no | output | 1 | Target chip select, active low |
| rw_o | output | 1 | 1 = read, 0 = write |
| ad_sel_o | output | 1 | 0 = address phase, 1 = data phase |
| bus_o | output | DW | Shared bus output value |
| bus_oe_o | output | DW | Per-bit output enable of the shared bus |
| bus_i | input | DW | Shared bus input value |

## Verification
The bench builds the block with a 5-bit bus, VOTES = 5, SET_BIT = 4 and GET_BIT = 3, and a 20 ns clock against a 70 ns settle minimum, so each phase lasts 4 cycles. With five votes an accepted read needs two matching earlier samples. The bench can therefore reach early acceptance after three samples, acceptance on the fifth sample, and exhaustion that returns a corrupted last sample. It also reaches a consistently wrong majority that is accepted. On the write side, a bus-side register model that can skip or refuse its mirrored state update produces a single retry and full exhaustion at five writes and fifteen reads.

// File: rtl/mrb_pkg.sv
`timescale 1ns/1ps
package mrb_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_ADDR,
    ST_DATA,
    ST_END
  } seq_st_e;

  // ceil(min_ns / clk_ns), never below one cycle
  function automatic int unsigned settle_cycles(input int unsigned clk_ns,
                                                input int unsigned min_ns);
    int unsigned c;
    c = (min_ns + clk_ns - 1) / clk_ns;
    return (c == 0) ? 1 : c;
  endfunction

endpackage

// File: rtl/mrb_settle_timer.sv
`timescale 1ns/1ps
module mrb_settle_timer #(
  parameter int unsigned CYC = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  output logic expired_o
);
  localparam int unsigned CW = (CYC > 1) ? $clog2(CYC) : 1;

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (load_i)         cnt_q <= CW'(CYC - 1);
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign expired_o = (cnt_q == '0);
endmodule

// File: rtl/mrb_vote_tracker.sv
`timescale 1ns/1ps
module mrb_vote_tracker #(
  parameter int unsigned W = 5,
  parameter int unsigned N = 5
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         push_i,
  input  logic [W-1:0] sample_i,
  output logic         accept_o
);
  localparam int unsigned IW   = $clog2(N + 1);
  localparam int unsigned NEED = N / 2;

  logic [W-1:0]  hist_q [N];
  logic [IW-1:0] idx_q;
  logic [N-1:0]  hit;
  logic [IW-1:0] hits;

  for (genvar j = 0; j < N; j++) begin : g_cmp
    assign hit[j] = (IW'(j) < idx_q) && (hist_q[j] == sample_i);
  end

  always_comb begin
    hits = '0;
    for (int j = 0; j < N; j++) hits = hits + IW'(hit[j]);
  end

  // accept on agreement, or when this is the final permitted sample
  assign accept_o = (hits >= IW'(NEED)) || (idx_q >= IW'(N - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q <= '0;
      for (int j = 0; j < N; j++) hist_q[j] <= '0;
    end else if (clr_i) begin
      idx_q <= '0;
    end else if (push_i && (idx_q < IW'(N))) begin
      hist_q[idx_q] <= sample_i;
      idx_q         <= idx_q + 1'b1;
    end
  end
endmodule

// File: rtl/mrb_verify_map.sv
`timescale 1ns/1ps
module mrb_verify_map #(
  parameter int unsigned W       = 5,
  parameter int unsigned SET_BIT = 4,
  parameter int unsigned GET_BIT = 3
) (
  input  logic [W-1:0] addr_i,
  output logic         is_set_o,
  output logic [W-1:0] chk_addr_o
);
  localparam logic [W-1:0] SET_M = W'(1) << SET_BIT;
  localparam logic [W-1:0] GET_M = W'(1) << GET_BIT;

  assign is_set_o   = addr_i[SET_BIT];
  assign chk_addr_o = (addr_i & ~SET_M) | GET_M;
endmodule

// File: rtl/mux_reg_bus_master.sv
`timescale 1ns/1ps
module mux_reg_bus_master
  import mrb_pkg::*;
#(
  parameter int unsigned DW        = 5,
  parameter int unsigned VOTES     = 5,
  parameter int unsigned CLK_NS    = 20,
  parameter int unsigned SETTLE_NS = 70,
  parameter int unsigned SET_BIT   = 4,
  parameter int unsigned GET_BIT   = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          we_i,
  input  logic [DW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic          done_o,
  output logic          fail_o,
  output logic [DW-1:0] rdata_o,
  output logic          cs_no,
  output logic          rw_o,
  output logic          ad_sel_o,
  output logic [DW-1:0] bus_o,
  output logic [DW-1:0] bus_oe_o,
  input  logic [DW-1:0] bus_i
);
  localparam int unsigned SETTLE_CYC = settle_cycles(CLK_NS, SETTLE_NS);
  localparam int unsigned TW         = $clog2(VOTES + 1);

  seq_st_e       st_q;
  logic          op_wr_q, we_q, acc_ok_q, done_q, fail_q;
  logic [DW-1:0] addr_q, wdata_q, acc_addr_q, smp_q, rdata_q;
  logic [TW-1:0] try_q;

  logic          tmr_load, tmr_exp, vote_push, vote_clr, vote_ok;
  logic          is_set;
  logic [DW-1:0] chk_addr;

  assign tmr_load  = (st_q == ST_SETUP) || (st_q == ST_ADDR && tmr_exp);
  assign vote_push = (st_q == ST_DATA) && tmr_exp && !op_wr_q;
  assign vote_clr  = (st_q == ST_IDLE) || op_wr_q;

  mrb_settle_timer #(.CYC(SETTLE_CYC)) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (tmr_load),
    .expired_o (tmr_exp)
  );

  mrb_vote_tracker #(.W(DW), .N(VOTES)) u_vote (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (vote_clr),
    .push_i   (vote_push),
    .sample_i (bus_i),
    .accept_o (vote_ok)
  );

  mrb_verify_map #(.W(DW), .SET_BIT(SET_BIT), .GET_BIT(GET_BIT)) u_map (
    .addr_i     (addr_q),
    .is_set_o   (is_set),
    .chk_addr_o (chk_addr)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_IDLE;
      op_wr_q    <= 1'b0;
      we_q       <= 1'b0;
      acc_ok_q   <= 1'b0;
      done_q     <= 1'b0;
      fail_q     <= 1'b0;
      addr_q     <= '0;
      wdata_q    <= '0;
      acc_addr_q <= '0;
      smp_q      <= '0;
      rdata_q    <= '0;
      try_q      <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (start_i) begin
          addr_q     <= addr_i;
          wdata_q    <= wdata_i;
          we_q       <= we_i;
          op_wr_q    <= we_i;
          acc_addr_q <= addr_i;
          try_q      <= '0;
          st_q       <= ST_SETUP;
        end
        ST_SETUP: st_q <= ST_ADDR;
        ST_ADDR:  if (tmr_exp) st_q <= ST_DATA;
        ST_DATA:  if (tmr_exp) begin
          if (!op_wr_q) begin
            smp_q    <= bus_i;
            acc_ok_q <= vote_ok;
          end
          st_q <= ST_END;
        end
        ST_END: begin
          if (op_wr_q) begin
            try_q <= try_q + 1'b1;
            if (is_set) begin
              op_wr_q    <= 1'b0;
              acc_addr_q <= chk_addr;
              st_q       <= ST_SETUP;
            end else begin
              done_q <= 1'b1;
              fail_q <= 1'b0;
              st_q   <= ST_IDLE;
            end
          end else if (!acc_ok_q) begin
            st_q <= ST_SETUP;
          end else if (we_q) begin
            if (smp_q == wdata_q) begin
              done_q <= 1'b1;
              fail_q <= 1'b0;
              st_q   <= ST_IDLE;
            end else if (try_q >= TW'(VOTES)) begin
              done_q <= 1'b1;
              fail_q <= 1'b1;
              st_q   <= ST_IDLE;
            end else begin
              op_wr_q    <= 1'b1;
              acc_addr_q <= addr_q;
              st_q       <= ST_SETUP;
            end
          end else begin
            rdata_q <= smp_q;
            done_q  <= 1'b1;
            fail_q  <= 1'b0;
            st_q    <= ST_IDLE;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  logic in_acc, drv_phase;
  assign in_acc    = (st_q == ST_ADDR) || (st_q == ST_DATA);
  assign drv_phase = (st_q == ST_SETUP) || (st_q == ST_ADDR) ||
                     ((st_q == ST_DATA) && op_wr_q);

  assign cs_no    = !in_acc;
  assign rw_o     = !(op_wr_q && ((st_q == ST_SETUP) || in_acc));
  assign ad_sel_o = (st_q == ST_DATA);
  assign bus_oe_o = {DW{drv_phase}};
  assign bus_o    = ((st_q == ST_DATA) && op_wr_q) ? wdata_q : acc_addr_q;
  assign done_o   = done_q;
  assign fail_o   = fail_q;
  assign rdata_o  = rdata_q;
endmodule

// File: rtl/mrb_checker.sv
`timescale 1ns/1ps
module mrb_checker #(
  parameter int unsigned DW     = 5,
  parameter int unsigned SETTLE = 4
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          done_o,
  input logic          fail_o,
  input logic          cs_no,
  input logic          rw_o,
  input logic          ad_sel_o,
  input logic [DW-1:0] bus_o,
  input logic [DW-1:0] bus_oe_o
);
  logic [15:0] lo_cnt, hi_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_cnt <= '0;
      hi_cnt <= '0;
    end else begin
      if (cs_no)          lo_cnt <= '0;
      else if (!ad_sel_o) lo_cnt <= lo_cnt + 1'b1;
      if (!ad_sel_o)      hi_cnt <= '0;
      else                hi_cnt <= hi_cnt + 1'b1;
    end
  end

  // R1
  idle_after_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (cs_no && rw_o && bus_oe_o == '0));

  // R2
  addr_before_cs_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cs_no) |-> (!ad_sel_o && (&bus_oe_o) && $stable(bus_o)));

  // R3
  addr_settle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ad_sel_o) |-> (lo_cnt == 16'(SETTLE)));

  // R3
  data_settle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cs_no) |-> (hi_cnt == 16'(SETTLE) && rw_o));

  // R4
  read_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_no && ad_sel_o && rw_o) |-> (bus_oe_o == '0));

  // R5
  write_drive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_no && ad_sel_o && !rw_o) |-> (&bus_oe_o));

  // R8
  fail_with_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fail_o) |-> done_o);

  // R9
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
endmodule

bind mux_reg_bus_master mrb_checker #(.DW(DW), .SETTLE(SETTLE_CYC)) u_mrb_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .done_o   (done_o),
  .fail_o   (fail_o),
  .cs_no    (cs_no),
  .rw_o     (rw_o),
  .ad_sel_o (ad_sel_o),
  .bus_o    (bus_o),
  .bus_oe_o (bus_oe_o)
);

// File: tb/mux_reg_bus_master_test.sv
`timescale 1ns/1ps
module mux_reg_bus_master_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0, we = 1'b0;
  logic [4:0] addr = '0, wdata = '0;
  logic       done_o, fail_o, cs_no, rw_o, ad_sel_o;
  logic [4:0] rdata_o, bus_o, bus_oe_o, bus_i;

  always #10 clk = ~clk;

  mux_reg_bus_master #(.DW(5), .VOTES(5), .CLK_NS(20), .SETTLE_NS(70),
                       .SET_BIT(4), .GET_BIT(3)) uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .done_o(done_o), .fail_o(fail_o),
    .rdata_o(rdata_o), .cs_no(cs_no), .rw_o(rw_o), .ad_sel_o(ad_sel_o),
    .bus_o(bus_o), .bus_oe_o(bus_oe_o), .bus_i(bus_i)
  );

  int n_chk = 0, n_bad = 0;

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // bus-side register target model, evaluated on falling edges
  logic [4:0] mem [32];
  logic [4:0] mask [8];
  logic [4:0] lat_a = '0, last_rd_a = '0;
  logic       cs_d = 1'b1, acc_rw = 1'b1;
  int rd_idx = 0, n_rd = 0, n_wr = 0, skip_left = 0;
  int ph_a = 0, ph_d = 0, ph_err = 0;
  bit stuck = 0;

  initial begin
    for (int i = 0; i < 32; i++) mem[i] = '0;
    for (int i = 0; i < 8; i++) mask[i] = '0;
  end

  assign bus_i = (!cs_no && ad_sel_o && rw_o)
                 ? (mem[lat_a] ^ ((rd_idx < 8) ? mask[rd_idx] : 5'h00)) : 5'h00;

  always @(negedge clk) begin
    if (!cs_no) begin
      acc_rw = rw_o;
      if (!ad_sel_o) begin
        lat_a = bus_o;
        ph_a++;
      end else begin
        ph_d++;
        if (!rw_o) begin
          mem[lat_a] = bus_o;
          if (lat_a[4] && !stuck && skip_left == 0)
            mem[(lat_a & 5'h0F) | 5'h08] = bus_o;
        end
      end
    end else if (!cs_d) begin
      if (ph_a != 4 || ph_d != 4) ph_err++;
      ph_a = 0;
      ph_d = 0;
      if (acc_rw) begin
        n_rd++;
        rd_idx++;
        last_rd_a = lat_a;
      end else begin
        n_wr++;
        if (lat_a[4] && skip_left > 0) skip_left--;
      end
    end
    cs_d = cs_no;
  end

  task automatic prep();
    @(negedge clk);
    rd_idx = 0; n_rd = 0; n_wr = 0; ph_err = 0; skip_left = 0; stuck = 0;
    for (int i = 0; i < 8; i++) mask[i] = '0;
  endtask

  task automatic wait_done();
    int t = 0;
    while (!done_o && t < 5000) begin
      @(negedge clk);
      t++;
    end
    check("R9 done seen", int'(done_o), 1);
    @(negedge clk);
    check("R9 done single cycle", int'(done_o), 0);
  endtask

  task automatic run(logic w, logic [4:0] a, logic [4:0] d);
    start = 1'b1; we = w; addr = a; wdata = d;
    @(negedge clk);
    start = 1'b0;
    wait_done();
  endtask

  task automatic t_reset();
    check("R1 reset cs", int'(cs_no), 1);
    check("R1 reset rw", int'(rw_o), 1);
    check("R1 reset oe", int'(bus_oe_o), 0);
    check("R1 reset done", int'(done_o), 0);
  endtask

  task automatic t_read_clean();
    prep();
    mem[7] = 5'h15;
    run(1'b0, 5'h07, 5'h00);
    check("R6 clean read value", int'(rdata_o), 'h15);
    check("R6 early stop at 3", n_rd, 3);
    check("R4 read makes no write", n_wr, 0);
    check("R3 phase lengths", ph_err, 0);
    check("R8 read clears flag", int'(fail_o), 0);
    check("R1 idle cs", int'(cs_no), 1);
    check("R1 idle rw", int'(rw_o), 1);
  endtask

  task automatic t_read_split();
    prep();
    mem[3] = 5'h0A;
    mask[0] = 5'h01; mask[1] = 5'h02;
    run(1'b0, 5'h03, 5'h00);
    check("R6 split vote value", int'(rdata_o), 'h0A);
    check("R6 split vote count", n_rd, 5);
  endtask

  task automatic t_read_last();
    prep();
    mem[9] = 5'h11;
    mask[1] = 5'h01; mask[2] = 5'h02; mask[3] = 5'h04; mask[4] = 5'h08;
    run(1'b0, 5'h09, 5'h00);
    check("R6 last sample returned", int'(rdata_o), 'h19);
    check("R6 exhausted count", n_rd, 5);
  endtask

  task automatic t_read_bad_major();
    prep();
    mem[4] = 5'h06;
    mask[0] = 5'h03; mask[1] = 5'h03; mask[2] = 5'h03;
    run(1'b0, 5'h04, 5'h00);
    check("R6 agreeing majority taken", int'(rdata_o), 'h05);
    check("R6 agreeing majority count", n_rd, 3);
  endtask

  task automatic t_write_plain();
    prep();
    mem[5] = 5'h00;
    run(1'b1, 5'h05, 5'h0C);
    check("R5 write stored", int'(mem[5]), 'h0C);
    check("R7 plain write single access", n_wr, 1);
    check("R7 plain write no readback", n_rd, 0);
    check("R8 plain write flag", int'(fail_o), 0);
    check("R6 rdata kept after write", int'(rdata_o), 'h05);
    check("R3 write phase lengths", ph_err, 0);
  endtask

  task automatic t_write_verify();
    prep();
    mem[5'h0A] = 5'h00;
    run(1'b1, 5'h12, 5'h1B);
    check("R7 verify write count", n_wr, 1);
    check("R7 verify read count", n_rd, 3);
    check("R7 verify address", int'(last_rd_a), 'h0A);
    check("R7 set register stored", int'(mem[5'h12]), 'h1B);
    check("R8 verify ok flag", int'(fail_o), 0);
  endtask

  task automatic t_write_retry();
    prep();
    mem[5'h0C] = 5'h00;
    skip_left = 1;
    run(1'b1, 5'h14, 5'h07);
    check("R8 one retry writes", n_wr, 2);
    check("R8 one retry reads", n_rd, 6);
    check("R8 retry ok flag", int'(fail_o), 0);
  endtask

  task automatic t_write_exhaust();
    prep();
    mem[5'h09] = 5'h00;
    stuck = 1;
    run(1'b1, 5'h11, 5'h13);
    check("R8 exhausted writes", n_wr, 5);
    check("R8 exhausted reads", n_rd, 15);
    check("R8 exhausted flag", int'(fail_o), 1);
    check("R9 rdata held", int'(rdata_o), 'h05);
    repeat (5) @(negedge clk);
    check("R9 flag held", int'(fail_o), 1);
  endtask

  task automatic t_busy_ignore();
    prep();
    mem[2] = 5'h1E;
    mem[6] = 5'h1F;
    start = 1'b1; we = 1'b0; addr = 5'h02; wdata = 5'h00;
    @(negedge clk);
    start = 1'b0;
    repeat (6) @(negedge clk);
    start = 1'b1; we = 1'b1; addr = 5'h06; wdata = 5'h01;
    @(negedge clk);
    start = 1'b0;
    wait_done();
    check("R10 original read value", int'(rdata_o), 'h1E);
    check("R10 no write issued", n_wr, 0);
    check("R10 read count", n_rd, 3);
    check("R8 read after exhaust clears flag", int'(fail_o), 0);
    repeat (20) @(negedge clk);
    check("R10 nothing queued", n_rd + n_wr, 3);
    check("R10 target untouched", int'(mem[6]), 'h1F);
  endtask

  initial begin
    #(200000 * 20);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_read_clean();
    t_read_split();
    t_read_last();
    t_read_bad_major();
    t_write_plain();
    t_write_verify();
    t_write_retry();
    t_write_exhaust();
    t_busy_ignore();
    $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
    $finish;
  end
endmodule